// File: doc/BRIEF.md
# System Configuration Register Bank

This block holds eleven 32-bit configuration registers behind a simple synchronous register bus. Each register carries a fixed storage mask and a per-bit access policy. A bit can be plain read/write, set-only (it sticks at 1 until reset), clear-only (it sticks at 0 until reset), or a hardware status flag that software clears by writing 1. Bits that no policy covers keep their reset value whatever is written.

Writes take effect on the rising clock edge when `bus_we` is high. Read data is a combinational function of `bus_addr` and the current register state. The four interrupt-line source select registers are also driven out continuously on `line_sel`, so that a neighbouring multiplexer can pick which port feeds each external interrupt line. A hardware event input raises the status flag in the second configuration register.

Top module: `cfgreg_bank`

## Requirements
- R1: After reset, the register at byte offset 0x04 reads 0x7C000001 and every other register reads 0x00000000.
- R2: The register index is `bus_addr[7:2]`, and `bus_addr[1:0]` are ignored. The registers sit at these byte offsets: 0x00 remap, 0x04 config1, 0x08/0x0C/0x10/0x14 select0..select3, 0x18 status, 0x1C config2, 0x20 protect1, 0x24 key, 0x28 protect2. Offsets from 0x2C upwards read 0 and writes to them change no register.
- R3: Plain read/write fields: remap stores only the bits of mask 0x00000107, each select register stores only bits [15:0], key stores only bits [7:0], and config1 stores only the bits of mask 0xFCFF0100. All other bits of these registers read back their reset value.
- R4: config1 bit 0 is clear-only. Writing 0 clears it, and a later write of 1 leaves it at 0 until reset.
- R5: config2 bits [3:0] are set-only. A write of 1 sets a bit, and a write of 0 does not clear it.
- R6: Every bit of protect1 and protect2 is set-only. The new value is the old value ORed with the write data.
- R7: config2 bit 8 is a status flag. A software write of 1 never sets it. A cycle with `hw_evt` high sets it. A write of 1 to it clears it, and this clear wins over an event in the same cycle. A write of 0 leaves it unchanged. The other config2 bits outside [3:0] and 8 read 0.
- R8: The status register at 0x18 always reads 0 and ignores writes.
- R9: `line_sel[16*k+15:16*k]` equals bits [15:0] of select register k, and it changes in the cycle after the write that changes it.
- R10: While `rst_n` is low at a rising edge, every register returns to its reset value, including set-only and cleared clear-only bits.
- R11: A write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 1 | Hardware event that sets the config2 status flag |
| line_sel | output | 64 | Four 16-bit interrupt-line source selections |

## Verification
On every cycle the assertions check several invariants. Protect and set-only bits never fall outside reset, and the clear-only bit never rises. Unmapped offsets read zero. At most one register takes a write. The status flag follows its set/clear precedence. Reserved bits of the remap and key registers stay zero, and the status register stays zero. Only the bench's scenarios can show the exact values after write sequences. Those scenarios also show that a write leaves every other register alone, that the select export tracks its registers, and the full set of reset values after a late reset.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DW       = 32;
  localparam int unsigned NREG     = 11;
  localparam int unsigned NSEL     = 4;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned FLAG_BIT = 8;

  typedef enum int unsigned {
    RG_REMAP = 0,
    RG_CFG1  = 1,
    RG_SEL0  = 2,
    RG_SEL1  = 3,
    RG_SEL2  = 4,
    RG_SEL3  = 5,
    RG_STAT  = 6,
    RG_CFG2  = 7,
    RG_PROT1 = 8,
    RG_KEY   = 9,
    RG_PROT2 = 10
  } reg_id_e;

  // per-bit policy of one register
  typedef struct packed {
    logic [DW-1:0] rst;   // reset value
    logic [DW-1:0] rw;    // plain read/write
    logic [DW-1:0] so;    // set-only
    logic [DW-1:0] co;    // clear-only
    logic [DW-1:0] w1c;   // hardware-set, write-one-to-clear
  } reg_policy_t;

  function automatic reg_policy_t policy_of(int unsigned idx);
    reg_policy_t p;
    p = '0;
    case (idx)
      RG_REMAP: p.rw = 32'h0000_0107;
      RG_CFG1: begin
        p.rst = 32'h7C00_0001;
        p.rw  = 32'hFCFF_0100;
        p.co  = 32'h0000_0001;
      end
      RG_SEL0, RG_SEL1, RG_SEL2, RG_SEL3: p.rw = 32'h0000_FFFF;
      RG_CFG2: begin
        p.so  = 32'h0000_000F;
        p.w1c = 32'h1 << FLAG_BIT;
      end
      RG_PROT1, RG_PROT2: p.so = 32'hFFFF_FFFF;
      RG_KEY: p.rw = 32'h0000_00FF;
      default: p = '0;
    endcase
    return p;
  endfunction

  // hardware set of status flags
  function automatic logic [DW-1:0] apply_hw(reg_policy_t p, logic [DW-1:0] cur,
                                             logic [DW-1:0] set_req);
    return cur | (p.w1c & set_req);
  endfunction

  // software write applied on top of the current value
  function automatic logic [DW-1:0] apply_write(reg_policy_t p, logic [DW-1:0] cur,
                                                logic [DW-1:0] wd);
    logic [DW-1:0] keep;
    keep = ~(p.rw | p.so | p.co | p.w1c);
    return (p.rw  & wd)
         | (p.so  & (cur | wd))
         | (p.co  & cur & wd)
         | (p.w1c & cur & ~wd)
         | (keep  & cur);
  endfunction

endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NREG   = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic [ADDR_W-3:0] idx,
  output logic              mapped,
  output logic [NREG-1:0]   wr_hit
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IW = ADDR_W - 2;

  logic unused_byte_lane;
  assign unused_byte_lane = ^addr[1:0];

  assign idx    = addr[ADDR_W-1:2];
  assign mapped = (idx < IW'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign wr_hit[g] = we && mapped && (idx == IW'(g));
  end
endmodule

// File: rtl/cfgreg_cell.sv
module cfgreg_cell
  import cfgreg_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam reg_policy_t P = policy_of(IDX);

  logic [DW-1:0] after_hw;
  logic [DW-1:0] nxt;

  always_comb begin
    after_hw = apply_hw(P, q, hw_set);
    nxt      = wr ? apply_write(P, after_hw, wdata) : after_hw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= P.rst;
    else        q <= nxt;
  end
endmodule

// File: rtl/cfgreg_rdmux.sv
module cfgreg_rdmux #(
  parameter int unsigned IW   = 6,
  parameter int unsigned NREG = 11,
  parameter int unsigned DW   = 32
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [IW-1:0]           idx,
  input  logic                    mapped,
  output logic [DW-1:0]           rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    rdata = '0;
    if (mapped) begin
      for (int i = 0; i < NREG; i++) begin
        if (idx == IW'(i)) rdata = regs[i];
      end
    end
  end
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
  import cfgreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  input  logic                    hw_evt,
  output logic [NSEL*SEL_W-1:0]   line_sel
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]           rd_idx;
  logic                    addr_mapped;
  logic [NREG-1:0]         wr_hit;
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] hw_set;

  cfgreg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .idx    (rd_idx),
    .mapped (addr_mapped),
    .wr_hit (wr_hit)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == RG_CFG2) begin : g_evt
      assign hw_set[g] = DW'(hw_evt) << FLAG_BIT;
    end else begin : g_noevt
      assign hw_set[g] = '0;
    end
    cfgreg_cell #(.IDX(g)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_hit[g]),
      .wdata  (bus_wdata),
      .hw_set (hw_set[g]),
      .q      (regs_q[g])
    );
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    assign line_sel[k*SEL_W +: SEL_W] = regs_q[RG_SEL0 + k][SEL_W-1:0];
  end

  cfgreg_rdmux #(.IW(IW), .NREG(NREG), .DW(DW)) u_rd (
    .regs   (regs_q),
    .idx    (rd_idx),
    .mapped (addr_mapped),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/cfgreg_chk.sv
module cfgreg_chk
  import cfgreg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [DW-1:0]           bus_wdata,
  input  logic [DW-1:0]           bus_rdata,
  input  logic                    hw_evt,
  input  logic                    addr_mapped,
  input  logic [NREG-1:0]         wr_hit,
  input  logic [NREG-1:0][DW-1:0] regs_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned I_REMAP = RG_REMAP;
  localparam int unsigned I_CFG1  = RG_CFG1;
  localparam int unsigned I_STAT  = RG_STAT;
  localparam int unsigned I_CFG2  = RG_CFG2;
  localparam int unsigned I_PROT1 = RG_PROT1;
  localparam int unsigned I_KEY   = RG_KEY;
  localparam int unsigned I_PROT2 = RG_PROT2;

  logic flag_clr_evt;
  assign flag_clr_evt = bus_we && wr_hit[I_CFG2] && bus_wdata[FLAG_BIT];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> bus_rdata == '0); // R2

  AST_RESERVED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs_q[I_KEY] & ~32'h0000_00FF) == '0) &&
    ((regs_q[I_REMAP] & ~32'h0000_0107) == '0)); // R3

  AST_CO_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$rose(regs_q[I_CFG1][0])); // R4

  AST_SO_NIBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((regs_q[I_CFG2][3:0] & $past(regs_q[I_CFG2][3:0])) == $past(regs_q[I_CFG2][3:0]))); // R5

  AST_PROT1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((regs_q[I_PROT1] & $past(regs_q[I_PROT1])) == $past(regs_q[I_PROT1]))); // R6

  AST_PROT2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((regs_q[I_PROT2] & $past(regs_q[I_PROT2])) == $past(regs_q[I_PROT2]))); // R6

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_evt |=> !regs_q[I_CFG2][FLAG_BIT]); // R7

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt && !flag_clr_evt) |=> regs_q[I_CFG2][FLAG_BIT]); // R7

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[I_STAT] == '0); // R8

  AST_RESET_VALUES: assert property (@(posedge clk)
    !rst_n |=> (regs_q[I_CFG1] == 32'h7C00_0001) && (regs_q[I_PROT1] == '0)
               && (regs_q[I_PROT2] == '0) && (regs_q[I_CFG2] == '0)); // R10

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R11
endmodule

bind cfgreg_bank cfgreg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .hw_evt      (hw_evt),
  .addr_mapped (addr_mapped),
  .wr_hit      (wr_hit),
  .regs_q      (regs_q)
);

// File: tb/sim_cfgreg_bank.sv
module sim_cfgreg_bank;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_evt = 1'b0;
  logic [63:0] line_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mdl [0:10];

  always #4 clk = ~clk;   // 125 MHz

  cfgreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt), .line_sel(line_sel)
  );

  // bench model of one write, from the requirements
  function automatic logic [31:0] model_wr(int idx, logic [31:0] cur, logic [31:0] wd);
    logic fl;
    case (idx)
      0: return wd & 32'h0000_0107;
      1: return {wd[31:26], 2'b00, wd[23:16], 7'b0, wd[8], 7'b0, cur[0] & wd[0]};
      2, 3, 4, 5: return {16'h0, wd[15:0]};
      6: return 32'h0;
      7: begin
        fl = wd[8] ? 1'b0 : cur[8];
        return {23'h0, fl, 4'h0, cur[3:0] | wd[3:0]};
      end
      8, 10: return cur | wd;
      9: return {24'h0, wd[7:0]};
      default: return cur;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      1: return "R4";
      6: return "R8";
      7: return "R5";
      8, 10: return "R6";
      default: return (idx > 10) ? "R2" : "R3";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 11; i++) mdl[i] = (i == 1) ? 32'h7C00_0001 : 32'h0;
  endtask

  task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a[7:2] < 11) mdl[a[7:2]] = model_wr(int'(a[7:2]), mdl[a[7:2]], d);
  endtask

  task automatic read_chk(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a;
    #1;
    e = (a[7:2] < 11) ? mdl[a[7:2]] : 32'h0;
    check(bus_rdata, e, tag);
  endtask

  task automatic sel_chk();
    #1;
    check(line_sel, {mdl[5][15:0], mdl[4][15:0], mdl[3][15:0], mdl[2][15:0]}, "R9");
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    logic [31:0] pats [0:5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h0000_0001; pats[5] = 32'h8000_0100;

    do_reset();
    // R1: reset state across every word offset (and R2 for unmapped)
    for (int a = 0; a < 256; a += 4) read_chk(8'(a), (a < 44) ? "R1" : "R2");
    sel_chk();

    // sweep: every pattern to every offset, then read back all offsets
    foreach (pats[p]) begin
      for (int t = 0; t < 16; t++) begin
        do_write(8'(t * 4), pats[p]);
        sel_chk();
        for (int a = 0; a < 16; a++)
          read_chk(8'(a * 4), (a == t) ? tag_of(a) : "R11");
      end
    end

    // R2: byte-lane bits ignored
    do_write(8'h26, 32'h0000_003C);
    read_chk(8'h24, "R2");
    read_chk(8'h27, "R2");
    do_write(8'hFC, 32'hFFFF_FFFF);
    for (int a = 0; a < 11; a++) read_chk(8'(a * 4), "R2");

    // R7: status flag behaviour
    do_reset();
    do_write(8'h1C, 32'h0000_0100);
    read_chk(8'h1C, "R7");                       // write 1 does not set
    @(negedge clk); hw_evt = 1'b1;
    @(negedge clk); hw_evt = 1'b0;
    mdl[7][8] = 1'b1;
    read_chk(8'h1C, "R7");                       // event sets
    do_write(8'h1C, 32'h0000_0000);
    read_chk(8'h1C, "R7");                       // write 0 keeps it
    do_write(8'h1C, 32'h0000_0100);
    read_chk(8'h1C, "R7");                       // write 1 clears
    @(negedge clk); hw_evt = 1'b1;
    @(negedge clk);
    bus_addr = 8'h1C; bus_we = 1'b1; bus_wdata = 32'h0000_0102;   // clear wins over event
    @(negedge clk);
    bus_we = 1'b0; hw_evt = 1'b0;
    mdl[7] = 32'h0000_0002;
    read_chk(8'h1C, "R7");

    // R10: reset clears sticky state
    do_write(8'h04, 32'h0);
    do_write(8'h20, 32'hFFFF_FFFF);
    do_write(8'h28, 32'h1234_5678);
    do_write(8'h1C, 32'h0000_000F);
    do_write(8'h08, 32'h0000_BEEF);
    do_reset();
    for (int a = 0; a < 11; a++) read_chk(8'(a * 4), "R10");
    sel_chk();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule